// File: doc/BRIEF.md
# Event-Driven Four-Step Process Sequencer

The block runs a fixed chain of external processes one after another. A step counter holds the index of the process that is running. The index drives a decoder that raises that process's enable line. The same index drives a multiplexer that watches only that process's completion line. When the watched process reports that it has finished, the counter moves on, the old enable drops and the next one rises. Each step takes as long as its process needs, because the sequencer moves on only when the process reports completion.

Completion lines come from outside the clock domain. Each one passes through a synchroniser and an edge detector before the multiplexer. Only a low-to-high transition on the line that is being watched counts, and a line that stays high counts once. After the last process reports, every enable is low and a finished flag stays high until the next start. The step count and the synchroniser depth are parameters. The default is four steps.

Top module: `step_sequencer`

## Requirements
- R1: While `rst` is high, and after `rst` falls with `start` low, every bit of `run_en_o` is 0 and `seq_done_o` is 0.
- R2: A clock edge with `start` high makes `run_en_o` equal to 1 (bit 0 only, first process) and `seq_done_o` 0 from the next cycle on.
- R3: While a sequence runs, exactly one bit of `run_en_o` is high. Bit k enables process k. The active bit moves from bit k to bit k+1 only, so the steps run in the order 0, 1, 2, 3.
- R4: Bit k of `done_i` belongs to process k. If bit k rises while process k is active, `run_en_o` is unchanged after two clock edges and has moved on after the third clock edge.
- R5: A completion line that stays high advances the sequence only once.
- R6: A rise on a completion line whose process is not active is ignored. A line that is already high when its step begins does not advance that step until the line falls and rises again.
- R7: When the last process reports completion, `run_en_o` becomes all 0 and `seq_done_o` becomes 1 on the same edge. `seq_done_o` then holds until a clock edge with `start` high.
- R8: While no sequence runs, `done_i` has no effect on `run_en_o` or `seq_done_o`.
- R9: `start` during a running or finished sequence restarts it at process 0 and clears `seq_done_o`. `start` takes priority over a completion on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous start or restart request |
| done_i | input | STEPS | Completion line of each process, asynchronous |
| run_en_o | output | STEPS | Registered enable of each process, at most one high |
| seq_done_o | output | 1 | Registered flag: the whole sequence has finished |

## Verification
The assertions assume that `start` and `rst` are synchronous to `clk`. They also assume that the enable vector changes only through `start`, a single step forward or the move to the finished state. They place no limit on `done_i`: any pattern, including lines that stay high and rises on lines that are not being watched, must leave those properties intact. The bench changes every input at the falling edge, so it stays inside these assumptions. It still drives completion rises on every line during every step and while the sequencer is idle.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= async_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/seq_route.sv
module seq_route #(
  parameter int STEPS = 4,
  localparam int IW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STEPS-1:0] lvl_i,
  input  logic [IW-1:0]    sel_i,
  output logic             adv_o
);
  logic [STEPS-1:0] prev_q;
  logic [STEPS-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;

  always_comb begin
    adv_o = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (sel_i == IW'(i)) adv_o = rise[i];
    end
  end
endmodule

// File: rtl/seq_decode.sv
module seq_decode #(
  parameter int STEPS = 4,
  localparam int IW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic [IW-1:0]    idx_i,
  output logic [STEPS-1:0] en_o
);
  genvar b;
  generate
    for (b = 0; b < STEPS; b++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) en_o[b] <= 1'b0;
        else     en_o[b] <= act_i && (idx_i == IW'(b));
      end
    end
  endgenerate
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int STEPS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [STEPS-1:0] done_i,
  output logic [STEPS-1:0] run_en_o,
  output logic             seq_done_o
);
  import seq_pkg::*;

  localparam int IW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [IW-1:0] LAST = IW'(STEPS - 1);

  phase_t        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          fin_d;
  logic [STEPS-1:0] done_s;
  logic          adv;

  seq_sync #(.W(STEPS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(done_i), .sync_o(done_s)
  );

  seq_route #(.STEPS(STEPS)) u_route (
    .clk(clk), .rst(rst), .lvl_i(done_s), .sel_i(idx_q), .adv_o(adv)
  );

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    fin_d   = seq_done_o;
    if (start) begin
      phase_d = PH_RUN;
      idx_d   = '0;
      fin_d   = 1'b0;
    end else if (phase_q == PH_RUN && adv) begin
      if (idx_q == LAST) begin
        phase_d = PH_IDLE;
        fin_d   = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      idx_q      <= '0;
      seq_done_o <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      idx_q      <= idx_d;
      seq_done_o <= fin_d;
    end
  end

  seq_decode #(.STEPS(STEPS)) u_dec (
    .clk(clk), .rst(rst), .act_i(phase_d == PH_RUN), .idx_i(idx_d), .en_o(run_en_o)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int STEPS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [STEPS-1:0] en,
  input logic             fin
);
  localparam logic [STEPS-1:0] FIRST = STEPS'(1);

  // R3: never more than one enable
  a_r3_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(en));

  // R2 / R9: start selects the first process and clears the finished flag
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    start |=> (en == FIRST) && !fin);

  // R3 / R7: enable moves one place up, or to the finished state
  a_r3_order: assert property (@(posedge clk) disable iff (rst)
    (!start && en != '0) |=> (en == $past(en)) || (en == ($past(en) << 1)) || (en == '0 && fin));

  // R7: finished means no enable
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst) fin |-> (en == '0));

  // R7: finished flag holds until start
  a_r7_hold: assert property (@(posedge clk) disable iff (rst) (fin && !start) |=> fin);

  // R8: idle stays idle without start
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (!start && en == '0) |=> (en == '0) && (fin == $past(fin)));
endmodule

bind step_sequencer seq_checker #(.STEPS(STEPS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .en(run_en_o), .fin(seq_done_o)
);

// File: tb/sim_step_sequencer.sv
module sim_step_sequencer;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] done_i = '0;
  logic [N-1:0] run_en_o;
  logic         seq_done_o;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  step_sequencer #(.STEPS(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .start(start), .done_i(done_i),
    .run_en_o(run_en_o), .seq_done_o(seq_done_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(3);
    check("R1 enables in reset", run_en_o, '0);
    check("R1 flag in reset", N'(seq_done_o), '0);
    rst = 1'b0;
    tick(2);
    check("R1 enables after reset", run_en_o, '0);

    // R8: completion activity while idle
    done_i = '1; tick(5); done_i = '0; tick(5);
    check("R8 idle enables", run_en_o, '0);
    check("R8 idle flag", N'(seq_done_o), '0);

    pulse_start();
    check("R2 first enable", run_en_o, N'(1));
    check("R2 flag clear", N'(seq_done_o), '0);

    for (int k = 0; k < N; k++) begin
      for (int j = 0; j < N; j++) begin
        if (j != k) begin
          done_i[j] = 1'b1; tick(4);
          check("R6 foreign rise ignored", run_en_o, N'(1) << k);
          done_i[j] = 1'b0; tick(4);
        end
      end
      done_i[k] = 1'b1;
      tick(2);
      check("R4 unchanged after two edges", run_en_o, N'(1) << k);
      tick(1);
      check("R4 advanced after third edge", run_en_o, (k == N-1) ? '0 : (N'(1) << (k+1)));
      tick(6);
      check("R5 held level counts once", run_en_o, (k == N-1) ? '0 : (N'(1) << (k+1)));
      done_i[k] = 1'b0;
      tick(3);
    end
    check("R7 all enables low", run_en_o, '0);
    check("R7 flag set", N'(seq_done_o), N'(1));

    for (int j = 0; j < N; j++) begin
      done_i[j] = 1'b1; tick(4); done_i[j] = 1'b0; tick(4);
    end
    check("R7 flag holds", N'(seq_done_o), N'(1));
    check("R8 no enable after finish", run_en_o, '0);

    pulse_start();
    check("R9 restart from finished", run_en_o, N'(1));
    check("R9 flag cleared", N'(seq_done_o), '0);
    for (int k = 0; k < 2; k++) begin
      done_i[k] = 1'b1; tick(3); done_i[k] = 1'b0; tick(3);
    end
    check("R3 third step active", run_en_o, N'(4));
    pulse_start();
    check("R9 restart mid run", run_en_o, N'(1));

    // R6: line already high when its step begins
    done_i[1] = 1'b1; tick(4);
    check("R6 early line ignored", run_en_o, N'(1));
    done_i[0] = 1'b1; tick(3); done_i[0] = 1'b0;
    check("R3 second step active", run_en_o, N'(2));
    tick(6);
    check("R6 pre-high line no advance", run_en_o, N'(2));
    done_i[1] = 1'b0; tick(3);
    done_i[1] = 1'b1; tick(3);
    check("R6 fresh rise advances", run_en_o, N'(4));
    done_i[1] = 1'b0;

    // R9: start wins over a completion on the same edge
    done_i[2] = 1'b1; tick(2);
    start = 1'b1; tick(1); start = 1'b0;
    check("R9 start priority", run_en_o, N'(1));
    done_i[2] = 1'b0; tick(3);
    check("R9 stays at first step", run_en_o, N'(1));

    finish_run();
  end
endmodule